// File: doc/BRIEF.md
# Double-Mantissa Operand Aligner

This block prepares two operands for addition in a number format that carries a sign, an exponent, a fixed fractional mantissa and a repeating mantissa, where each mantissa has its own length. Before the mantissas can be added, their last fixed digits must have the same weight. The block computes the signed alignment distance from the gap between the exponents and the gap between the fixed lengths. It then extends the operand that ends at the higher weight. The extension moves the boundary between the fixed digits and the repeating digits of that operand.

Moving the boundary by k digits does two things. It appends the next k repeating digits to the tail of the fixed field, and it rotates the repeating field left by k within its own period, so the field starts at the new boundary. The period length does not change. Exponents are unsigned. Digits are binary. Both fields are right-justified: the first fixed digit is at bit `flen-1` and the first repeating digit is at bit `plen-1`. The block takes one operand pair per handshake and produces a registered result one cycle later.

Top module: `dm_align_top`

## Requirements
- R1: `out_disp` equals (a_exp − b_exp) − (a_flen − b_flen) as a two's-complement value of DISP_W bits.
- R2: A positive displacement sets `out_moved_a` and only operand A is extended. A negative displacement sets `out_moved_b` and only operand B is extended. The two flags are never set together.
- R3: For the extended operand, with k digits applied, the new fixed field equals the old fixed field shifted left by k, with repeating digits 0..k−1 (taken cyclically, first digit at bit plen−1) placed in the k low bits in order.
- R4: For the extended operand, the new repeating field is the old one rotated left by k within plen bits: new digit i equals old digit (i+k) mod plen.
- R5: For the extended operand, the new fixed length is the old fixed length plus k, and k equals the displacement magnitude when no overflow occurs.
- R6: If the old fixed length plus the displacement magnitude exceeds MANT_W, `out_ovf` is 1, k is MANT_W minus the old fixed length, and the new fixed length is MANT_W. Otherwise `out_ovf` is 0.
- R7: A zero displacement sets neither moved flag and clears `out_ovf`. Both operands then leave with their lengths and fields unchanged.
- R8: Input bits above `flen` in a fixed field and above `plen` in a repeating field have no effect. The corresponding output bits are 0, and the operand that is not extended leaves with its masked fields and its length unchanged.
- R9: A pair accepted on a cycle with `in_valid` and `in_ready` both high appears on the outputs after the next clock edge with `out_valid` high. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the outputs hold.
- R10: While `rst_n` is low at a clock edge, `out_valid` is cleared and `in_ready` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can accept a pair |
| a_exp | input | EXP_W | Exponent of A (unsigned) |
| a_flen | input | LEN_W | Fixed digit count of A (0..MANT_W) |
| a_plen | input | LEN_W | Repeating digit count of A (1..MANT_W) |
| a_fix | input | MANT_W | Fixed digits of A, right-justified |
| a_per | input | MANT_W | Repeating digits of A, right-justified |
| b_exp | input | EXP_W | Exponent of B (unsigned) |
| b_flen | input | LEN_W | Fixed digit count of B |
| b_plen | input | LEN_W | Repeating digit count of B |
| b_fix | input | MANT_W | Fixed digits of B |
| b_per | input | MANT_W | Repeating digits of B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts the result |
| out_disp | output | DISP_W | Signed displacement |
| out_moved_a | output | 1 | A was extended |
| out_moved_b | output | 1 | B was extended |
| out_ovf | output | 1 | Extension clamped at MANT_W |
| out_a_flen | output | LEN_W | New fixed length of A |
| out_a_fix | output | MANT_W | New fixed digits of A |
| out_a_per | output | MANT_W | Rotated repeating digits of A |
| out_b_flen | output | LEN_W | New fixed length of B |
| out_b_fix | output | MANT_W | New fixed digits of B |
| out_b_per | output | MANT_W | Rotated repeating digits of B |

## Verification
The result is registered one cycle after acceptance, so a fault in the shift-step chain or in the displacement arithmetic shows up in the very next result. Such a fault produces a wrong low-order fixed digit, a mis-rotated repeating field, or a wrong moved flag. A wrong head-digit index, for example, usually damages every extended operand whose period is shorter than MANT_W. An off-by-one in the overflow clamp only shows when the fixed length lands exactly on MANT_W, which is why the sweep covers every combination of fixed lengths and exponents in a small configuration. A stale output register under backpressure shows up as a changed field in the cycles while `out_ready` is low.

// File: rtl/dm_align_pkg.sv
// Package: shared encodings and helpers for the double-mantissa aligner.
// Assumes mantissa widths of at most 64 bits.
package dm_align_pkg;

    // Which operand has its fixed/repeating boundary moved.
    typedef enum logic [1:0] {
        MOVE_NONE = 2'd0,
        MOVE_A    = 2'd1,
        MOVE_B    = 2'd2
    } move_e;

    // Mask with the n low bits set; n of 64 or more gives all ones.
    function automatic logic [63:0] low_mask(input logic [7:0] n);
        if (n >= 8'd64) return '1;
        return (64'd1 << n) - 64'd1;
    endfunction

endpackage

// File: rtl/dm_disp_calc.sv
// Module: dm_disp_calc
// Computes the signed alignment distance (exponent gap minus fixed-length
// gap) with complement-and-add subtractors, and derives the operand to move
// and the distance magnitude. Assumes DISP_W holds the full range of results.
module dm_disp_calc
    import dm_align_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int LEN_W  = 4,
    parameter int DISP_W = 7
) (
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [LEN_W-1:0]  a_flen,
    input  logic [LEN_W-1:0]  b_flen,
    output logic [DISP_W-1:0] disp,
    output logic [DISP_W-1:0] mag,
    output move_e             move
);

    logic [DISP_W-1:0] ea_x, eb_x, la_x, lb_x;
    logic [DISP_W-1:0] exp_gap, len_gap;

    // Widen both pairs so that the modular sums carry the sign correctly.
    always_comb begin
        ea_x = {{(DISP_W-EXP_W){1'b0}}, a_exp};
        eb_x = {{(DISP_W-EXP_W){1'b0}}, b_exp};
        la_x = {{(DISP_W-LEN_W){1'b0}}, a_flen};
        lb_x = {{(DISP_W-LEN_W){1'b0}}, b_flen};
    end

    // Three complement-and-add steps: both gaps, then the displacement.
    always_comb begin
        exp_gap = ea_x + ~eb_x + {{(DISP_W-1){1'b0}}, 1'b1};
        len_gap = la_x + ~lb_x + {{(DISP_W-1){1'b0}}, 1'b1};
        disp    = exp_gap + ~len_gap + {{(DISP_W-1){1'b0}}, 1'b1};
    end

    // The sign picks the operand; the magnitude is the step count.
    always_comb begin
        if (disp == '0) begin
            move = MOVE_NONE;
            mag  = '0;
        end else if (disp[DISP_W-1]) begin
            move = MOVE_B;
            mag  = ~disp + {{(DISP_W-1){1'b0}}, 1'b1};
        end else begin
            move = MOVE_A;
            mag  = disp;
        end
    end

    // R2: a nonzero magnitude always names an operand, a zero one never does.
    always_comb begin
        a_r2_mag_vs_move: assert ((mag == '0) == (move == MOVE_NONE))
            else $error("R2: magnitude and move selection disagree");
    end

endmodule

// File: rtl/dm_digit_step.sv
// Module: dm_digit_step
// One boundary step: when enabled, appends the head repeating digit to the
// fixed field and rotates the repeating field left by one inside plen bits.
// Assumes 1 <= plen <= MANT_W and inputs already masked to their lengths.
module dm_digit_step
    import dm_align_pkg::*;
#(
    parameter int MANT_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic              en,
    input  logic [LEN_W-1:0]  plen,
    input  logic [MANT_W-1:0] fix_i,
    input  logic [MANT_W-1:0] per_i,
    output logic [MANT_W-1:0] fix_o,
    output logic [MANT_W-1:0] per_o
);

    logic [MANT_W-1:0] pmask;
    logic              head;
    logic [LEN_W-1:0]  head_idx;

    // Locate the first repeating digit and the period mask.
    always_comb begin
        pmask    = low_mask(8'(plen))[MANT_W-1:0];
        head_idx = plen - {{(LEN_W-1){1'b0}}, 1'b1};
        head     = (plen != '0) ? per_i[head_idx] : 1'b0;
    end

    // Apply the step or pass the fields through.
    always_comb begin
        if (en) begin
            fix_o = {fix_i[MANT_W-2:0], head};
            per_o = {per_i[MANT_W-2:0], head} & pmask;
        end else begin
            fix_o = fix_i;
            per_o = per_i;
        end
    end

endmodule

// File: rtl/dm_period_shift.sv
// Module: dm_period_shift
// Moves the fixed/repeating boundary by 'steps' digits using an unrolled
// chain of MANT_W single-digit stages. Assumes steps <= MANT_W - flen so the
// fixed field never loses a digit, and inputs masked to their lengths.
module dm_period_shift #(
    parameter int MANT_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic [LEN_W-1:0]  steps,
    input  logic [LEN_W-1:0]  plen,
    input  logic [MANT_W-1:0] fix_i,
    input  logic [MANT_W-1:0] per_i,
    output logic [MANT_W-1:0] fix_o,
    output logic [MANT_W-1:0] per_o
);

    logic [MANT_W-1:0] fix_c [MANT_W+1];
    logic [MANT_W-1:0] per_c [MANT_W+1];

    // Feed the chain with the incoming fields.
    always_comb begin
        fix_c[0] = fix_i;
        per_c[0] = per_i;
    end

    genvar s;
    generate
        for (s = 0; s < MANT_W; s++) begin : g_stage
            localparam logic [LEN_W-1:0] IDX = LEN_W'(s);
            logic stage_en;
            assign stage_en = (IDX < steps);
            dm_digit_step #(.MANT_W(MANT_W), .LEN_W(LEN_W)) u_step (
                .en    (stage_en),
                .plen  (plen),
                .fix_i (fix_c[s]),
                .per_i (per_c[s]),
                .fix_o (fix_c[s+1]),
                .per_o (per_c[s+1])
            );
        end
    endgenerate

    // Take the fields from the end of the chain.
    always_comb begin
        fix_o = fix_c[MANT_W];
        per_o = per_c[MANT_W];
    end

    // R4: a rotation keeps the number of set digits in the period.
    always_comb begin
        if (plen != '0) begin
            a_r4_rotation_keeps_ones: assert ($countones(per_o) == $countones(per_i))
                else $error("R4: rotation changed the repeating digit count");
        end
    end

endmodule

// File: rtl/dm_align_top.sv
// Module: dm_align_top
// Aligns two double-mantissa operands: computes the displacement, extends the
// operand whose fixed part ends at the higher weight, clamps at MANT_W with
// an overflow flag, and registers the result behind a valid/ready pair.
// Assumes flen <= MANT_W, 1 <= plen <= MANT_W, MANT_W <= 64.
module dm_align_top
    import dm_align_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int MANT_W = 8,
    parameter int LEN_W  = $clog2(MANT_W + 1),
    parameter int DISP_W = ((EXP_W > LEN_W) ? EXP_W : LEN_W) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [LEN_W-1:0]  a_flen,
    input  logic [LEN_W-1:0]  a_plen,
    input  logic [MANT_W-1:0] a_fix,
    input  logic [MANT_W-1:0] a_per,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [LEN_W-1:0]  b_flen,
    input  logic [LEN_W-1:0]  b_plen,
    input  logic [MANT_W-1:0] b_fix,
    input  logic [MANT_W-1:0] b_per,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DISP_W-1:0] out_disp,
    output logic              out_moved_a,
    output logic              out_moved_b,
    output logic              out_ovf,
    output logic [LEN_W-1:0]  out_a_flen,
    output logic [MANT_W-1:0] out_a_fix,
    output logic [MANT_W-1:0] out_a_per,
    output logic [LEN_W-1:0]  out_b_flen,
    output logic [MANT_W-1:0] out_b_fix,
    output logic [MANT_W-1:0] out_b_per
);

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MANT_W);

    logic [DISP_W-1:0] disp, mag;
    move_e             move;
    logic [MANT_W-1:0] a_fix_m, a_per_m, b_fix_m, b_per_m;
    logic [LEN_W-1:0]  sel_flen, sel_plen, room, steps, new_flen;
    logic [MANT_W-1:0] sel_fix, sel_per, sh_fix, sh_per;
    logic              ovf;

    // Clear every digit above the declared field lengths.
    always_comb begin
        a_fix_m = a_fix & low_mask(8'(a_flen))[MANT_W-1:0];
        a_per_m = a_per & low_mask(8'(a_plen))[MANT_W-1:0];
        b_fix_m = b_fix & low_mask(8'(b_flen))[MANT_W-1:0];
        b_per_m = b_per & low_mask(8'(b_plen))[MANT_W-1:0];
    end

    dm_disp_calc #(.EXP_W(EXP_W), .LEN_W(LEN_W), .DISP_W(DISP_W)) u_disp (
        .a_exp  (a_exp),
        .b_exp  (b_exp),
        .a_flen (a_flen),
        .b_flen (b_flen),
        .disp   (disp),
        .mag    (mag),
        .move   (move)
    );

    // Route the operand to be extended into the single shifter.
    always_comb begin
        if (move == MOVE_B) begin
            sel_flen = b_flen;
            sel_plen = b_plen;
            sel_fix  = b_fix_m;
            sel_per  = b_per_m;
        end else begin
            sel_flen = a_flen;
            sel_plen = a_plen;
            sel_fix  = a_fix_m;
            sel_per  = a_per_m;
        end
    end

    // Limit the step count to the free room in the fixed field.
    always_comb begin
        room = FULL_LEN - sel_flen;
        if (mag > {{(DISP_W-LEN_W){1'b0}}, room}) begin
            ovf   = 1'b1;
            steps = room;
        end else begin
            ovf   = 1'b0;
            steps = mag[LEN_W-1:0];
        end
        new_flen = sel_flen + steps;
    end

    dm_period_shift #(.MANT_W(MANT_W), .LEN_W(LEN_W)) u_shift (
        .steps (steps),
        .plen  (sel_plen),
        .fix_i (sel_fix),
        .per_i (sel_per),
        .fix_o (sh_fix),
        .per_o (sh_per)
    );

    // Accept a new pair whenever the output slot is free or being drained.
    always_comb in_ready = !out_valid || out_ready;

    // Output valid flag with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (in_ready) out_valid <= in_valid;
    end

    // Capture the aligned pair on acceptance.
    always_ff @(posedge clk) begin
        if (rst_n && in_ready && in_valid) begin
            out_disp    <= disp;
            out_moved_a <= (move == MOVE_A);
            out_moved_b <= (move == MOVE_B);
            out_ovf     <= ovf;
            out_a_flen  <= (move == MOVE_A) ? new_flen : a_flen;
            out_a_fix   <= (move == MOVE_A) ? sh_fix   : a_fix_m;
            out_a_per   <= (move == MOVE_A) ? sh_per   : a_per_m;
            out_b_flen  <= (move == MOVE_B) ? new_flen : b_flen;
            out_b_fix   <= (move == MOVE_B) ? sh_fix   : b_fix_m;
            out_b_per   <= (move == MOVE_B) ? sh_per   : b_per_m;
        end
    end

    // R2: the moved flag matches the sign of the registered displacement.
    a_r2_flag_follows_sign: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_moved_a == ($signed(out_disp) > 0)) &&
                      (out_moved_b == ($signed(out_disp) < 0)))
        else $error("R2: moved flag disagrees with displacement sign");

    // R5: a fixed length never exceeds the register width.
    a_r5_flen_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_a_flen <= FULL_LEN) && (out_b_flen <= FULL_LEN))
        else $error("R5: fixed length beyond register width");

    // R6: an overflow leaves the extended operand full.
    a_r6_ovf_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ovf |->
            ((out_moved_a ? out_a_flen : out_b_flen) == FULL_LEN))
        else $error("R6: overflow without clamped length");

    // R7: a zero displacement moves nothing and never overflows.
    a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_disp == '0) |-> !out_moved_a && !out_moved_b && !out_ovf)
        else $error("R7: zero displacement moved an operand");

    // R9: an accepted pair is presented on the next cycle.
    a_r9_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid)
        else $error("R9: accepted pair not presented");

    // R9: a stalled result holds steady.
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_disp) &&
            $stable(out_a_fix) && $stable(out_b_fix) &&
            $stable(out_a_per) && $stable(out_b_per))
        else $error("R9: stalled result changed");

endmodule

// File: tb/dm_align_top_test.sv
module dm_align_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int EXP_W  = 3;
    localparam int MANT_W = 6;
    localparam int LEN_W  = 3;
    localparam int DISP_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [EXP_W-1:0]  a_exp = '0, b_exp = '0;
    logic [LEN_W-1:0]  a_flen = '0, a_plen = 3'd1, b_flen = '0, b_plen = 3'd1;
    logic [MANT_W-1:0] a_fix = '0, a_per = '0, b_fix = '0, b_per = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [DISP_W-1:0] out_disp;
    logic              out_moved_a, out_moved_b, out_ovf;
    logic [LEN_W-1:0]  out_a_flen, out_b_flen;
    logic [MANT_W-1:0] out_a_fix, out_a_per, out_b_fix, out_b_per;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dm_align_top #(.EXP_W(EXP_W), .MANT_W(MANT_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .a_exp(a_exp), .a_flen(a_flen), .a_plen(a_plen), .a_fix(a_fix), .a_per(a_per),
        .b_exp(b_exp), .b_flen(b_flen), .b_plen(b_plen), .b_fix(b_fix), .b_per(b_per),
        .out_valid(out_valid), .out_ready(out_ready), .out_disp(out_disp),
        .out_moved_a(out_moved_a), .out_moved_b(out_moved_b), .out_ovf(out_ovf),
        .out_a_flen(out_a_flen), .out_a_fix(out_a_fix), .out_a_per(out_a_per),
        .out_b_flen(out_b_flen), .out_b_fix(out_b_fix), .out_b_per(out_b_per)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int msk(input int n);
        return (1 << n) - 1;
    endfunction

    // Digit j (0 = first) of a right-justified field of length p.
    function automatic int dig(input int v, input int p, input int j);
        return (v >> (p - 1 - j)) & 1;
    endfunction

    // Expected extension of one operand by k requested steps.
    task automatic extend(input int f, input int p, input int fx, input int pr, input int k,
                          output int nf, output int nfx, output int npr, output bit ov);
        int room, st, fm, pm;
        fm = fx & msk(f);
        pm = pr & msk(p);
        room = MANT_W - f;
        ov = (k > room);
        st = ov ? room : k;
        nf = f + st;
        nfx = fm << st;
        for (int j = 0; j < st; j++) nfx |= dig(pm, p, j % p) << (st - 1 - j);
        npr = 0;
        for (int i = 0; i < p; i++) npr |= dig(pm, p, (i + st) % p) << (p - 1 - i);
    endtask

    task automatic drive(input int ea, input int fa, input int pa, input int xa, input int ya,
                         input int eb, input int fb, input int pb, input int xb, input int yb);
        a_exp = EXP_W'(ea); a_flen = LEN_W'(fa); a_plen = LEN_W'(pa);
        a_fix = MANT_W'(xa); a_per = MANT_W'(ya);
        b_exp = EXP_W'(eb); b_flen = LEN_W'(fb); b_plen = LEN_W'(pb);
        b_fix = MANT_W'(xb); b_per = MANT_W'(yb);
    endtask

    // Compare the presented result against the arithmetic model.
    task automatic verify(input int ea, input int fa, input int pa, input int xa, input int ya,
                          input int eb, input int fb, input int pb, input int xb, input int yb);
        int d, nf, nfx, npr;
        bit ov;
        string tf, tp, tl, tq;
        d = (ea - eb) - (fa - fb);
        chk("R9 out_valid", int'(out_valid), 1);
        chk("R1 disp", int'($signed(out_disp)), d);
        chk("R2 moved_a", int'(out_moved_a), int'(d > 0));
        chk("R2 moved_b", int'(out_moved_b), int'(d < 0));
        tq = (d == 0) ? "R7 unchanged" : "R8 untouched operand";
        if (d > 0) begin
            extend(fa, pa, xa, ya, d, nf, nfx, npr, ov);
            tf = ov ? "R6 fix" : "R3 fix"; tp = "R4 per"; tl = ov ? "R6 flen" : "R5 flen";
            chk("R6 ovf", int'(out_ovf), int'(ov));
            chk(tl, int'(out_a_flen), nf);
            chk(tf, int'(out_a_fix), nfx);
            chk(tp, int'(out_a_per), npr);
            chk(tq, int'(out_b_flen), fb);
            chk(tq, int'(out_b_fix), xb & msk(fb));
            chk(tq, int'(out_b_per), yb & msk(pb));
        end else if (d < 0) begin
            extend(fb, pb, xb, yb, -d, nf, nfx, npr, ov);
            tf = ov ? "R6 fix" : "R3 fix"; tp = "R4 per"; tl = ov ? "R6 flen" : "R5 flen";
            chk("R6 ovf", int'(out_ovf), int'(ov));
            chk(tl, int'(out_b_flen), nf);
            chk(tf, int'(out_b_fix), nfx);
            chk(tp, int'(out_b_per), npr);
            chk(tq, int'(out_a_flen), fa);
            chk(tq, int'(out_a_fix), xa & msk(fa));
            chk(tq, int'(out_a_per), ya & msk(pa));
        end else begin
            chk("R7 ovf", int'(out_ovf), 0);
            chk(tq, int'(out_a_flen), fa);
            chk(tq, int'(out_a_fix), xa & msk(fa));
            chk(tq, int'(out_a_per), ya & msk(pa));
            chk(tq, int'(out_b_flen), fb);
            chk(tq, int'(out_b_fix), xb & msk(fb));
            chk(tq, int'(out_b_per), yb & msk(pb));
        end
    endtask

    initial begin
        int idx;
        idx = 0;
        // R10: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 out_valid in reset", int'(out_valid), 0);
        chk("R10 in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep every exponent and fixed-length combination (R1..R8).
        for (int ea = 0; ea < 8; ea++)
            for (int eb = 0; eb < 8; eb++)
                for (int fa = 0; fa <= MANT_W; fa++)
                    for (int fb = 0; fb <= MANT_W; fb++) begin
                        int pa, pb, xa, ya, xb, yb;
                        pa = 1 + (idx % MANT_W);
                        pb = 1 + ((idx / 7) % MANT_W);
                        xa = (idx * 29 + 5) & 63;
                        ya = (idx * 53 + 17) & 63;
                        xb = (idx * 41 + 11) & 63;
                        yb = (idx * 23 + 38) & 63;
                        drive(ea, fa, pa, xa, ya, eb, fb, pb, xb, yb);
                        in_valid = 1'b1;
                        @(negedge clk);
                        in_valid = 1'b0;
                        verify(ea, fa, pa, xa, ya, eb, fb, pb, xb, yb);
                        idx++;
                    end

        // R9: backpressure holds the result and blocks new input.
        @(negedge clk);
        out_ready = 1'b0;
        drive(5, 1, 3, 6'b000101, 6'b000110, 2, 4, 2, 6'b001011, 6'b000001);
        in_valid = 1'b1;
        @(negedge clk);
        drive(1, 0, 5, 6'b111111, 6'b010011, 6, 2, 4, 6'b000010, 6'b001001);
        for (int w = 0; w < 3; w++) begin
            chk("R9 in_ready while stalled", int'(in_ready), 0);
            verify(5, 1, 3, 6'b000101, 6'b000110, 2, 4, 2, 6'b001011, 6'b000001);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        verify(1, 0, 5, 6'b111111, 6'b010011, 6, 2, 4, 6'b000010, 6'b001001);
        @(negedge clk);
        chk("R9 out_valid drops when idle", int'(out_valid), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule